// File: doc/BRIEF.md
# OTP Programming Mode Entry Controller

This block decides how a microcontroller-style device comes out of reset: in normal operation, or on a path toward a parallel one-time-programmable (OTP) programming and test mode. Three boot strap pins are captured when reset is released. If all three are low, the device is armed rather than put straight into test mode. Test mode is entered only when the Port 2 value equals the entry key, the core reports that it is idle, and strap bit 2 (the external-access line) rises, all in the same cycle.

Once test mode is active, Port 2 is forced to input direction. A test latch, writable only in test mode, selects the sense-amplifier mode. Byte programming stays gated until a verify cycle has been run with the sense amplifiers in a verify mode and the security result allows it. Program requests made while programming is locked are dropped and recorded in a sticky error flag. The OTP array, the high-voltage pulse timing and the pad drivers belong to other blocks.

Top module: `otp_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `mode_normal` is 1, and `mode_armed`, `mode_test`, `p2_dir_in`, `tl_value`, `prog_enable`, `prog_ack` and `prog_err` are all 0.
- R2: `boot_strap` is captured in the last clock cycle of reset. A captured value of 3'b000 sets `mode_armed` one clock after release. Any other value keeps `mode_normal` at 1 and never leads to test mode.
- R3: From the armed state, `mode_test` rises one clock after a cycle in which `boot_strap[2]` goes from 0 to 1 while `p2_value` is 8'h30 and `core_idle` is 1. If the key or the idle flag is wrong at that rise, the controller stays armed.
- R4: `p2_dir_in` (1 = input) is 1 exactly when test mode is active.
- R5: A write through `tl_we`/`tl_wdata` loads `tl_value` one clock later, but only when test mode is active. Outside test mode a write leaves `tl_value` at 0.
- R6: `sa_verify` is 1 when `tl_value` is 8'h01 or 8'h09. `sa_dc_read` is 1 only for 8'h09.
- R7: `prog_enable` is set one clock after a `vfy_strobe` with `vfy_sec_ok` = 1, provided test mode is active and `sa_verify` is 1. A strobe with `vfy_sec_ok` = 0 leaves it at 0. A strobe while `sa_verify` is 0 has no effect.
- R8: A `prog_req` seen while `prog_enable` is 1 gives a one-cycle `prog_ack` pulse on the next clock. A `prog_req` in test mode while `prog_enable` is 0 gives no ack and sets `prog_err`, which stays set until reset.
- R9: Writing a test-latch code that is not a verify code clears `prog_enable` on the clock after `tl_value` changes.
- R10: Asserting reset from test mode returns every flag, the latch and the program gate to the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release is the strap capture point |
| boot_strap | input | 3 | Strap pins; bit 2 is also the external-access line whose rise activates test mode |
| p2_value | input | 8 | Current Port 2 contents |
| core_idle | input | 1 | Idle bit from the power-control register |
| tl_we | input | 1 | Test-latch write strobe |
| tl_wdata | input | 8 | Test-latch write data |
| vfy_strobe | input | 1 | A verify or other read cycle has completed |
| vfy_sec_ok | input | 1 | Security result of that cycle: 1 = programming allowed |
| prog_req | input | 1 | Byte-program request |
| mode_normal | output | 1 | Normal operation |
| mode_armed | output | 1 | Strap code 000 captured; waiting for activation |
| mode_test | output | 1 | Parallel programming/test mode active |
| p2_dir_in | output | 1 | Port 2 forced to input |
| tl_value | output | 8 | Test-latch contents |
| sa_verify | output | 1 | Sense amplifiers in a verify mode |
| sa_dc_read | output | 1 | Verify with DC read selected |
| prog_enable | output | 1 | Programming unlocked |
| prog_ack | output | 1 | Program request accepted (one-cycle pulse) |
| prog_err | output | 1 | Sticky: a request was made while locked |

## Verification
The assertions assume that the inputs are synchronous to `clk`, and that the strap pins keep their value through the last reset cycle so the captured code is well defined. They also assume that `vfy_strobe` and `prog_req` are single-cycle strobes whose effect can be traced to the previous clock. The bench drives every input just after a falling edge, holds the straps steady across the release of reset, and raises each strobe for exactly one cycle. Every mode-changing property can then be checked against the inputs of the previous cycle.

// File: rtl/otp_entry_pkg.sv
// Shared types and constants for the OTP programming-mode entry controller.
// Assumes an 8-bit port and test-latch data path.
package otp_entry_pkg;
    localparam int DATA_W = 8;
    localparam int STRAP_W = 3;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'd0,
        MD_ARMED  = 2'd1,
        MD_TEST   = 2'd2
    } mode_e;

    localparam logic [DATA_W-1:0] P2_ENTRY_KEY   = 8'h30;
    localparam logic [DATA_W-1:0] TL_VERIFY      = 8'h01;
    localparam logic [DATA_W-1:0] TL_VERIFY_DC   = 8'h09;
endpackage

// File: rtl/otp_mode_fsm.sv
// Mode sequencer: captures the strap pins during reset, decides normal or
// armed on the first cycle after release, and moves from armed to test on a
// rise of the external-access strap line while the port key and idle flag hold.
// Assumes inputs are synchronous to clk. Test mode is left only through reset.
module otp_mode_fsm
    import otp_entry_pkg::*;
#(
    parameter int                 DW      = DATA_W,
    parameter int                 SW      = STRAP_W,
    parameter logic [DW-1:0]      KEY     = P2_ENTRY_KEY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] strap,
    input  logic [DW-1:0] port_val,
    input  logic          idle,
    output mode_e         mode
);
    localparam int EXT_BIT = SW - 1;

    logic [SW-1:0] strap_cap;
    logic          first_q;
    logic          ext_q;
    logic          ext_rise;
    logic          entry_ok;

    assign ext_rise = strap[EXT_BIT] & ~ext_q;
    assign entry_ok = (port_val == KEY) & idle & ext_rise;

    // Capture straps in reset and track the external-access line for edges.
    always_ff @(posedge clk) begin
        ext_q <= strap[EXT_BIT];
        if (!rst_n) begin
            strap_cap <= strap;
            first_q   <= 1'b1;
        end else begin
            first_q   <= 1'b0;
        end
    end

    // Mode state: decision after release, then armed-to-test activation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MD_NORMAL;
        end else if (first_q) begin
            mode <= (strap_cap == '0) ? MD_ARMED : MD_NORMAL;
        end else if (mode == MD_ARMED && entry_ok) begin
            mode <= MD_TEST;
        end
    end
endmodule

// File: rtl/otp_test_latch.sv
// Test latch: holds the sense-amplifier mode code. Writes are taken only
// while the write permission input is high. Decodes the verify codes.
// Assumes wr_allow reflects registered test-mode state.
module otp_test_latch
    import otp_entry_pkg::*;
#(
    parameter int            DW     = DATA_W,
    parameter logic [DW-1:0] C_VFY  = TL_VERIFY,
    parameter logic [DW-1:0] C_VDC  = TL_VERIFY_DC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_allow,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q,
    output logic          sa_verify,
    output logic          sa_dc
);
    // Latch register, loaded only under permission.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we && wr_allow)
            q <= wdata;
    end

    // Decode of the sense-amplifier mode from the stored code.
    always_comb begin
        sa_dc     = (q == C_VDC);
        sa_verify = (q == C_VFY) | sa_dc;
    end
endmodule

// File: rtl/otp_prog_gate.sv
// Program gate: unlocks programming after a verify with a permissive security
// result, acknowledges requests when unlocked, and flags requests made while
// locked. Assumes vfy_strobe and req are single-cycle strobes.
module otp_prog_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic test_active,
    input  logic sa_verify,
    input  logic vfy_strobe,
    input  logic vfy_sec_ok,
    input  logic req,
    output logic enable,
    output logic ack,
    output logic err
);
    // Unlock state follows verify outcomes and drops when verify mode is left.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b0;
        else if (!test_active || !sa_verify)
            enable <= 1'b0;
        else if (vfy_strobe)
            enable <= vfy_sec_ok;
    end

    // Request handling: one-cycle ack when unlocked, sticky error otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            err <= 1'b0;
        end else begin
            ack <= test_active & req & enable;
            if (test_active && req && !enable)
                err <= 1'b1;
        end
    end
endmodule

// File: rtl/otp_entry_ctrl.sv
// Top of the OTP programming-mode entry controller. Ties the mode sequencer,
// the test latch and the program gate together and decodes the mode flags.
// Assumes all inputs are synchronous to clk; rst_n is synchronous active-low.
module otp_entry_ctrl
    import otp_entry_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STRAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] boot_strap,
    input  logic [DW-1:0] p2_value,
    input  logic          core_idle,
    input  logic          tl_we,
    input  logic [DW-1:0] tl_wdata,
    input  logic          vfy_strobe,
    input  logic          vfy_sec_ok,
    input  logic          prog_req,
    output logic          mode_normal,
    output logic          mode_armed,
    output logic          mode_test,
    output logic          p2_dir_in,
    output logic [DW-1:0] tl_value,
    output logic          sa_verify,
    output logic          sa_dc_read,
    output logic          prog_enable,
    output logic          prog_ack,
    output logic          prog_err
);
    mode_e mode;

    otp_mode_fsm #(.DW(DW), .SW(SW)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (boot_strap),
        .port_val (p2_value),
        .idle     (core_idle),
        .mode     (mode)
    );

    // Mode flag decode; Port 2 direction follows test mode.
    always_comb begin
        mode_normal = (mode == MD_NORMAL);
        mode_armed  = (mode == MD_ARMED);
        mode_test   = (mode == MD_TEST);
        p2_dir_in   = mode_test;
    end

    otp_test_latch #(.DW(DW)) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_allow  (mode_test),
        .we        (tl_we),
        .wdata     (tl_wdata),
        .q         (tl_value),
        .sa_verify (sa_verify),
        .sa_dc     (sa_dc_read)
    );

    otp_prog_gate i_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_active (mode_test),
        .sa_verify   (sa_verify),
        .vfy_strobe  (vfy_strobe),
        .vfy_sec_ok  (vfy_sec_ok),
        .req         (prog_req),
        .enable      (prog_enable),
        .ack         (prog_ack),
        .err         (prog_err)
    );
endmodule

// File: rtl/otp_entry_chk.sv
// Checker for the OTP entry controller, bound to the top module.
// Assumes single-cycle strobes and straps stable across reset release.
module otp_entry_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] p2_value,
    input logic       core_idle,
    input logic       tl_we,
    input logic       vfy_strobe,
    input logic       vfy_sec_ok,
    input logic       prog_req,
    input logic       mode_normal,
    input logic       mode_armed,
    input logic       mode_test,
    input logic       p2_dir_in,
    input logic [7:0] tl_value,
    input logic       sa_verify,
    input logic       prog_enable,
    input logic       prog_ack,
    input logic       prog_err
);
    logic live_q;

    // Marks cycles after the first clock out of reset so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode_normal, mode_armed, mode_test}) == 1);

    // R2
    armed_before_test_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $rose(mode_test) |-> $past(mode_armed));

    // R3
    key_at_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $rose(mode_test) |-> ($past(p2_value) == 8'h30 && $past(core_idle)));

    // R4
    port_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_test |-> p2_dir_in);

    // R5
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        !$stable(tl_value) |-> $past(mode_test && tl_we));

    // R7
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $rose(prog_enable) |-> $past(vfy_strobe && vfy_sec_ok && sa_verify));

    // R8
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        prog_ack |-> $past(prog_req && prog_enable));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(prog_err) |-> prog_err);
endmodule

bind otp_entry_ctrl otp_entry_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .p2_value    (p2_value),
    .core_idle   (core_idle),
    .tl_we       (tl_we),
    .vfy_strobe  (vfy_strobe),
    .vfy_sec_ok  (vfy_sec_ok),
    .prog_req    (prog_req),
    .mode_normal (mode_normal),
    .mode_armed  (mode_armed),
    .mode_test   (mode_test),
    .p2_dir_in   (p2_dir_in),
    .tl_value    (tl_value),
    .sa_verify   (sa_verify),
    .prog_enable (prog_enable),
    .prog_ack    (prog_ack),
    .prog_err    (prog_err)
);

// File: tb/test_otp_entry_ctrl.sv
// Directed bench for otp_entry_ctrl: one task per scenario.
module test_otp_entry_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] boot_strap = 3'b000;
    logic [7:0] p2_value = 8'h00;
    logic       core_idle = 1'b0;
    logic       tl_we = 1'b0;
    logic [7:0] tl_wdata = 8'h00;
    logic       vfy_strobe = 1'b0;
    logic       vfy_sec_ok = 1'b0;
    logic       prog_req = 1'b0;
    logic       mode_normal, mode_armed, mode_test, p2_dir_in;
    logic [7:0] tl_value;
    logic       sa_verify, sa_dc_read, prog_enable, prog_ack, prog_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    otp_entry_ctrl i_otp_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .p2_value(p2_value),
        .core_idle(core_idle), .tl_we(tl_we), .tl_wdata(tl_wdata),
        .vfy_strobe(vfy_strobe), .vfy_sec_ok(vfy_sec_ok), .prog_req(prog_req),
        .mode_normal(mode_normal), .mode_armed(mode_armed), .mode_test(mode_test),
        .p2_dir_in(p2_dir_in), .tl_value(tl_value), .sa_verify(sa_verify),
        .sa_dc_read(sa_dc_read), .prog_enable(prog_enable), .prog_ack(prog_ack),
        .prog_err(prog_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Reset with a strap value, release, and step past the first decision edge.
    task automatic do_reset(input logic [2:0] s);
        rst_n = 1'b0; boot_strap = s; p2_value = 8'h00; core_idle = 1'b0;
        tl_we = 1'b0; vfy_strobe = 1'b0; vfy_sec_ok = 1'b0; prog_req = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic enter_test();
        do_reset(3'b000);
        p2_value = 8'h30; core_idle = 1'b1; boot_strap = 3'b100;
        step();
    endtask

    task automatic write_tl(input logic [7:0] d);
        tl_we = 1'b1; tl_wdata = d; step(); tl_we = 1'b0;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; boot_strap = 3'b000;
        step(); step();
        check("R1 normal", mode_normal, 1);
        check("R1 armed", mode_armed, 0);
        check("R1 test", mode_test, 0);
        check("R1 latch", tl_value, 0);
        check("R1 gate", {prog_enable, prog_ack, prog_err, p2_dir_in}, 0);
    endtask

    task automatic t_strap_decode();
        do_reset(3'b010);
        check("R2 nonzero strap normal", mode_normal, 1);
        p2_value = 8'h30; core_idle = 1'b1; boot_strap = 3'b110; step(); step();
        check("R2 nonzero strap never test", mode_test, 0);
        do_reset(3'b000);
        check("R2 zero strap armed", mode_armed, 1);
    endtask

    task automatic t_entry_wrong();
        do_reset(3'b000);
        p2_value = 8'h31; core_idle = 1'b1; boot_strap = 3'b100; step();
        check("R3 wrong key stays armed", {mode_armed, mode_test}, 2'b10);
        do_reset(3'b000);
        p2_value = 8'h30; core_idle = 1'b0; boot_strap = 3'b100; step();
        check("R3 not idle stays armed", {mode_armed, mode_test}, 2'b10);
        core_idle = 1'b1; step();
        check("R3 no new rise stays armed", mode_test, 0);
    endtask

    task automatic t_entry_ok();
        enter_test();
        check("R3 entry", mode_test, 1);
        check("R4 port input", p2_dir_in, 1);
    endtask

    task automatic t_latch_outside();
        do_reset(3'b000);
        write_tl(8'h01);
        check("R5 write ignored when armed", tl_value, 0);
        do_reset(3'b111);
        write_tl(8'h09);
        check("R5 write ignored when normal", {tl_value, sa_verify}, 0);
        check("R4 port not input in normal", p2_dir_in, 0);
    endtask

    task automatic t_latch_codes();
        enter_test();
        write_tl(8'h01);
        check("R5 latch loaded", tl_value, 8'h01);
        check("R6 verify code", {sa_verify, sa_dc_read}, 2'b10);
        write_tl(8'h09);
        check("R6 verify dc code", {sa_verify, sa_dc_read}, 2'b11);
        write_tl(8'h05);
        check("R6 other code", {sa_verify, sa_dc_read}, 2'b00);
    endtask

    task automatic t_prog_blocked();
        enter_test();
        vfy_strobe = 1'b1; vfy_sec_ok = 1'b1; step(); vfy_strobe = 1'b0;
        step();
        check("R7 verify without verify mode ignored", prog_enable, 0);
        write_tl(8'h01);
        prog_req = 1'b1; step(); prog_req = 1'b0;
        check("R8 early request no ack", prog_ack, 0);
        check("R8 early request error", prog_err, 1);
        vfy_strobe = 1'b1; vfy_sec_ok = 1'b0; step(); vfy_strobe = 1'b0;
        step();
        check("R7 security blocks", prog_enable, 0);
        prog_req = 1'b1; step(); prog_req = 1'b0;
        check("R8 blocked request no ack", prog_ack, 0);
        step();
        check("R8 error sticky", prog_err, 1);
    endtask

    task automatic t_prog_ok();
        enter_test();
        write_tl(8'h09);
        vfy_strobe = 1'b1; vfy_sec_ok = 1'b1; step(); vfy_strobe = 1'b0;
        check("R7 unlocked", prog_enable, 1);
        prog_req = 1'b1; step(); prog_req = 1'b0;
        check("R8 ack pulse", prog_ack, 1);
        step();
        check("R8 ack single cycle", prog_ack, 0);
        check("R8 no error", prog_err, 0);
        write_tl(8'h00);
        check("R9 latch changed", tl_value, 0);
        step();
        check("R9 enable dropped", prog_enable, 0);
    endtask

    task automatic t_reset_midway();
        enter_test();
        write_tl(8'h01);
        vfy_strobe = 1'b1; vfy_sec_ok = 1'b1; step(); vfy_strobe = 1'b0;
        prog_req = 1'b1; step(); prog_req = 1'b0;
        rst_n = 1'b0; step();
        check("R10 flags cleared", {mode_normal, mode_armed, mode_test, p2_dir_in}, 4'b1000);
        check("R10 latch and gate cleared", {tl_value, prog_enable, prog_ack, prog_err}, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset_state();
        t_strap_decode();
        t_entry_wrong();
        t_entry_ok();
        t_latch_outside();
        t_latch_codes();
        t_prog_blocked();
        t_prog_ok();
        t_reset_midway();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule